// File: doc/BRIEF.md
# Character Display Host Bus Port

This block is the processor-facing side of a character display controller. It watches a register-select line, a read/write line and an enable strobe, and it serves a bidirectional data bus. The bus is normally eight bits wide. It can also run four bits wide, using only the top data lines. Each transfer is taken when the enable strobe falls.

Completed writes go to the controller core as a one-cycle strobe. The strobe carries the byte and a flag telling an instruction from display data. Reads return one of two values: the busy flag joined with the address counter, or RAM data supplied by the core. The port also tells the core when a data read has finished, so the core can advance its address.

The core chooses the bus width through a width-update input. The port reports the active width, and it enters a test mode when it sees a particular pattern of instructions on the narrow bus.

A three-state machine tracks the bus phase:
- `PH_WIDE`: eight-bit transfers.
- `PH_UPPER`: four-bit mode, waiting for the high nibble.
- `PH_LOWER`: four-bit mode, waiting for the low nibble.

The transitions are:
- A width update selecting four bits moves `PH_WIDE` to `PH_UPPER`.
- A width update selecting eight bits moves either narrow state to `PH_WIDE`.
- An enable fall moves `PH_UPPER` to `PH_LOWER` and `PH_LOWER` back to `PH_UPPER`.
- If a width update and an enable fall arrive in the same cycle, the width update wins and that transfer is dropped.

Top module: `lcd_host_port`

## Requirements
- R1: After reset the port is in eight-bit mode (`wide_mode`=1), `test_mode`=0, the bus output enable is low and no strobe is raised.
- R2: Bus inputs pass through a two-stage synchronizer. `bus_d_oe` is high exactly when the synchronized enable is high and the synchronized read/write line is 1.
- R3: Transfers are decoded from RS/RW as follows: RS=0,RW=0 is an instruction write; RS=0,RW=1 is a status read; RS=1,RW=0 is a data write; RS=1,RW=1 is a data read. Each complete write raises `cmd_valid` for exactly one cycle after the enable falls. `cmd_is_data` is 1 for a data write and 0 for an instruction write, and `cmd_byte` carries the byte.
- R4: A status read drives `core_busy` on bit 7 and `core_ac` on bits 6..0. A data read drives `core_rd_data`. A written instruction can never be read back.
- R5: In four-bit mode only lines 7..4 carry data. The high nibble comes first. The strobe is raised only after the second nibble, and lines 3..0 are ignored.
- R6: In four-bit mode, the read in the high-nibble phase shows bits 7..4 of the read byte on lines 7..4. The next read shows bits 3..0 there. Lines 3..0 are driven 0 in both phases.
- R7: `rd_done` pulses for one cycle after each complete data read: one byte in eight-bit mode, the second nibble in four-bit mode. Status reads never raise it.
- R8: When `fs_valid` is high, `fs_dl`=0 selects four-bit mode and `fs_dl`=1 selects eight-bit mode. Any width change returns the nibble phase to the high nibble.
- R9: An instruction byte 00h is never forwarded to the core. In eight-bit mode it has no other effect.
- R10: In four-bit mode, two consecutive complete instruction writes of 00h set `test_mode`. Any other complete write between them restarts the count. Selecting eight-bit mode clears `test_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Enable strobe; transfer taken on its falling edge |
| bus_d_in | input | 8 | Data bus, host to port |
| bus_d_out | output | 8 | Data bus, port to host |
| bus_d_oe | output | 1 | Output enable for the data bus |
| core_busy | input | 1 | Busy flag from the core |
| core_ac | input | 7 | Address counter from the core |
| core_rd_data | input | 8 | RAM read byte from the core |
| fs_valid | input | 1 | Width update from a function-set instruction |
| fs_dl | input | 1 | New width: 1 eight-bit, 0 four-bit |
| cmd_valid | output | 1 | One-cycle strobe for a complete write byte |
| cmd_is_data | output | 1 | 1 data write, 0 instruction write |
| cmd_byte | output | 8 | Assembled byte |
| rd_done | output | 1 | One-cycle strobe after a complete data read |
| wide_mode | output | 1 | 1 while the bus is eight bits wide |
| test_mode | output | 1 | Test mode entered |

## Verification
The bench targets the nibble boundary in several ways:
- It checks that nothing is strobed after a lone high nibble. A port that strobes per nibble would forward half-bytes.
- It leaves a stray high nibble pending, then switches the width to eight bits and back. A port that keeps its phase across a width change would splice the stale nibble into the next byte.
- It drives junk on the low lines during narrow writes, which exposes a port that reads the wrong lines.
- It puts a data write between two 00h instructions. A port that counts zeros without restarting would enter test mode too early.
- It checks that 00h in eight-bit mode is swallowed without side effects.
- It checks that status reads never pulse the read-completion strobe.

// File: rtl/lcd_port_pkg.sv
package lcd_port_pkg;

    typedef enum logic [1:0] {
        PH_WIDE  = 2'd0,
        PH_UPPER = 2'd1,
        PH_LOWER = 2'd2
    } phase_e;

endpackage

// File: rtl/lcd_bus_sync.sv
module lcd_bus_sync #(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rs_in,
    input  logic              rw_in,
    input  logic              en_in,
    input  logic [DATA_W-1:0] d_in,
    output logic              rs_s,
    output logic              rw_s,
    output logic              en_s,
    output logic [DATA_W-1:0] d_s,
    output logic              en_fall
);
    localparam int SW = DATA_W + 3;

    logic [SW-1:0] pipe [STAGES];
    logic          en_last;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[0] <= '0;
                else        pipe[0] <= {rs_in, rw_in, en_in, d_in};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign {rs_s, rw_s, en_s, d_s} = pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_last <= 1'b0;
        else        en_last <= en_s;
    end

    assign en_fall = en_last & ~en_s;

endmodule

// File: rtl/lcd_nibble_fsm.sv
module lcd_nibble_fsm
    import lcd_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_fall,
    input  logic              rs_s,
    input  logic              rw_s,
    input  logic [DATA_W-1:0] d_s,
    input  logic              fs_valid,
    input  logic              fs_dl,
    output phase_e            phase,
    output logic              cmd_valid,
    output logic              cmd_is_data,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              rd_done,
    output logic              test_mode
);
    localparam int NIB_W = DATA_W / 2;

    phase_e            state, state_nx;
    logic [NIB_W-1:0]  hi_nib;
    logic              hold_rs, hold_rw;
    logic              zero_seen;
    logic              width_chg;
    logic              byte_done;
    logic [DATA_W-1:0] asm_byte;
    logic              kind_rs, kind_rw;
    logic              is_zero_instr;

    assign width_chg = fs_valid && (fs_dl != (state == PH_WIDE));
    assign byte_done = !width_chg && en_fall &&
                       (state == PH_WIDE || state == PH_LOWER);
    assign asm_byte  = (state == PH_LOWER) ? {hi_nib, d_s[DATA_W-1 -: NIB_W]} : d_s;
    assign kind_rs   = (state == PH_LOWER) ? hold_rs : rs_s;
    assign kind_rw   = (state == PH_LOWER) ? hold_rw : rw_s;
    assign is_zero_instr = !kind_rs && !kind_rw && (asm_byte == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_WIDE: begin
                if (width_chg) state_nx = PH_UPPER;
            end
            PH_UPPER: begin
                if (width_chg)    state_nx = PH_WIDE;
                else if (en_fall) state_nx = PH_LOWER;
            end
            PH_LOWER: begin
                if (width_chg)    state_nx = PH_WIDE;
                else if (en_fall) state_nx = PH_UPPER;
            end
            default: state_nx = PH_WIDE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_WIDE;
        else        state <= state_nx;
    end

    assign phase = state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_nib      <= '0;
            hold_rs     <= 1'b0;
            hold_rw     <= 1'b0;
            cmd_valid   <= 1'b0;
            cmd_is_data <= 1'b0;
            cmd_byte    <= '0;
            rd_done     <= 1'b0;
            zero_seen   <= 1'b0;
            test_mode   <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            rd_done   <= 1'b0;
            if (width_chg) begin
                zero_seen <= 1'b0;
                test_mode <= 1'b0;
            end else begin
                if (en_fall && state == PH_UPPER) begin
                    hi_nib  <= d_s[DATA_W-1 -: NIB_W];
                    hold_rs <= rs_s;
                    hold_rw <= rw_s;
                end
                if (byte_done && !kind_rw) begin
                    cmd_valid   <= !is_zero_instr;
                    cmd_is_data <= kind_rs;
                    cmd_byte    <= asm_byte;
                    if (is_zero_instr && state == PH_LOWER) begin
                        if (zero_seen) test_mode <= 1'b1;
                        zero_seen <= 1'b1;
                    end else begin
                        zero_seen <= 1'b0;
                    end
                end
                if (byte_done && kind_rw && kind_rs) rd_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_read_mux.sv
module lcd_read_mux
    import lcd_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  logic              en_s,
    input  logic              rs_s,
    input  logic              rw_s,
    input  logic              busy,
    input  logic [DATA_W-2:0] ac,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe
);
    localparam int NIB_W = DATA_W / 2;

    logic [DATA_W-1:0] rbyte;

    assign rbyte = rs_s ? rd_data : {busy, ac};
    assign d_oe  = en_s & rw_s;

    always_comb begin
        unique case (phase)
            PH_UPPER: d_out = {rbyte[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
            PH_LOWER: d_out = {rbyte[NIB_W-1:0], {NIB_W{1'b0}}};
            default:  d_out = rbyte;
        endcase
    end

endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
    import lcd_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rs,
    input  logic              bus_rw,
    input  logic              bus_en,
    input  logic [DATA_W-1:0] bus_d_in,
    output logic [DATA_W-1:0] bus_d_out,
    output logic              bus_d_oe,
    input  logic              core_busy,
    input  logic [DATA_W-2:0] core_ac,
    input  logic [DATA_W-1:0] core_rd_data,
    input  logic              fs_valid,
    input  logic              fs_dl,
    output logic              cmd_valid,
    output logic              cmd_is_data,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              rd_done,
    output logic              wide_mode,
    output logic              test_mode
);
    logic              rs_s, rw_s, en_s, en_fall;
    logic [DATA_W-1:0] d_s;
    phase_e            phase;

    lcd_bus_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rs_in   (bus_rs),
        .rw_in   (bus_rw),
        .en_in   (bus_en),
        .d_in    (bus_d_in),
        .rs_s    (rs_s),
        .rw_s    (rw_s),
        .en_s    (en_s),
        .d_s     (d_s),
        .en_fall (en_fall)
    );

    lcd_nibble_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_fall     (en_fall),
        .rs_s        (rs_s),
        .rw_s        (rw_s),
        .d_s         (d_s),
        .fs_valid    (fs_valid),
        .fs_dl       (fs_dl),
        .phase       (phase),
        .cmd_valid   (cmd_valid),
        .cmd_is_data (cmd_is_data),
        .cmd_byte    (cmd_byte),
        .rd_done     (rd_done),
        .test_mode   (test_mode)
    );

    lcd_read_mux #(.DATA_W(DATA_W)) u_mux (
        .phase   (phase),
        .en_s    (en_s),
        .rs_s    (rs_s),
        .rw_s    (rw_s),
        .busy    (core_busy),
        .ac      (core_ac),
        .rd_data (core_rd_data),
        .d_out   (bus_d_out),
        .d_oe    (bus_d_oe)
    );

    assign wide_mode = (phase == PH_WIDE);

endmodule

// File: rtl/lcd_host_port_chk.sv
module lcd_host_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rw,
    input logic              bus_en,
    input logic [DATA_W-1:0] bus_d_out,
    input logic              bus_d_oe,
    input logic              fs_valid,
    input logic              fs_dl,
    input logic              cmd_valid,
    input logic              cmd_is_data,
    input logic [DATA_W-1:0] cmd_byte,
    input logic              rd_done,
    input logic              wide_mode,
    input logic              test_mode
);
    localparam int NIB_W = DATA_W / 2;

    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe |-> ($past(bus_en, 2) && $past(bus_rw, 2)));          // R2

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);                                      // R3

    AST_ZERO_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_is_data) |-> (cmd_byte != '0));              // R9

    AST_TEST_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> !wide_mode);                                      // R10

    AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && cmd_valid));                                       // R7

    AST_LOW_LINES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_d_oe && !wide_mode) |-> (bus_d_out[NIB_W-1:0] == '0));     // R6

    AST_WIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_valid && fs_dl) |=> wide_mode);                             // R8

endmodule

bind lcd_host_port lcd_host_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rw      (bus_rw),
    .bus_en      (bus_en),
    .bus_d_out   (bus_d_out),
    .bus_d_oe    (bus_d_oe),
    .fs_valid    (fs_valid),
    .fs_dl       (fs_dl),
    .cmd_valid   (cmd_valid),
    .cmd_is_data (cmd_is_data),
    .cmd_byte    (cmd_byte),
    .rd_done     (rd_done),
    .wide_mode   (wide_mode),
    .test_mode   (test_mode)
);

// File: tb/lcd_host_port_bench.sv
`timescale 1ns/1ps
module lcd_host_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rs = 1'b0, bus_rw = 1'b0, bus_en = 1'b0;
    logic [7:0] bus_d_in = 8'h00;
    logic [7:0] bus_d_out;
    logic       bus_d_oe;
    logic       core_busy = 1'b0;
    logic [6:0] core_ac = 7'h00;
    logic [7:0] core_rd_data = 8'h00;
    logic       fs_valid = 1'b0, fs_dl = 1'b0;
    logic       cmd_valid, cmd_is_data, rd_done, wide_mode, test_mode;
    logic [7:0] cmd_byte;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    logic [8:0] exp_q[$];
    logic [8:0] obs_q[$];
    logic h_cur = 1'b0, h_prev = 1'b0;

    always #10 clk = ~clk;

    lcd_host_port u_lcd_host_port (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor and per-clock output-enable model
    always @(posedge clk) begin
        if (cmd_valid) obs_q.push_back({cmd_is_data, cmd_byte});
        if (rd_done) rd_cnt++;
        h_prev = h_cur;
        h_cur  = bus_en & bus_rw & rst_n;
    end

    always @(negedge clk) begin
        chk("R2 oe", int'(bus_d_oe), int'(h_prev & rst_n));
    end

    task automatic settle(); repeat (6) @(negedge clk); endtask

    task automatic xfer(input logic rs, input logic rw, input logic [7:0] d,
                        output logic [7:0] seen);
        @(negedge clk);
        bus_rs = rs; bus_rw = rw; bus_d_in = d; bus_en = 1'b1;
        repeat (4) @(negedge clk);
        seen = bus_d_out;
        bus_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr8(input logic rs, input logic [7:0] b);
        logic [7:0] s;
        xfer(rs, 1'b0, b, s);
        if (!(rs == 1'b0 && b == 8'h00)) exp_q.push_back({rs, b});
    endtask

    task automatic wr4(input logic rs, input logic [7:0] b);
        logic [7:0] s;
        xfer(rs, 1'b0, {b[7:4], 4'hA}, s);
        xfer(rs, 1'b0, {b[3:0], 4'h5}, s);
        if (!(rs == 1'b0 && b == 8'h00)) exp_q.push_back({rs, b});
    endtask

    task automatic cmp_cmds(input string req);
        settle();
        chk({req, " count"}, obs_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
            chk({req, " byte"}, int'(obs_q[i]), int'(exp_q[i]));
        exp_q.delete();
        obs_q.delete();
    endtask

    task automatic set_width(input logic dl);
        @(negedge clk);
        fs_valid = 1'b1; fs_dl = dl;
        @(negedge clk);
        fs_valid = 1'b0;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s, s2;
        int rd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 wide", int'(wide_mode), 1);
        chk("R1 test", int'(test_mode), 0);
        chk("R1 no strobe", obs_q.size(), 0);

        // R3 eight-bit writes, R9 zero instruction swallowed
        wr8(1'b0, 8'h38);
        wr8(1'b1, 8'h41);
        wr8(1'b0, 8'h00);
        cmp_cmds("R3 R9");
        chk("R9 no test in wide", int'(test_mode), 0);

        // R4 status/data reads, R7 read completion
        core_busy = 1'b1; core_ac = 7'h25; core_rd_data = 8'h5C;
        rd0 = rd_cnt;
        xfer(1'b0, 1'b1, 8'h00, s);
        chk("R4 status busy", int'(s), 8'hA5);
        settle();
        chk("R7 status no rd_done", rd_cnt - rd0, 0);
        core_busy = 1'b0; core_ac = 7'h7F;
        xfer(1'b0, 1'b1, 8'h00, s);
        chk("R4 status ready", int'(s), 8'h7F);
        xfer(1'b1, 1'b1, 8'h00, s);
        chk("R4 data read", int'(s), 8'h5C);
        settle();
        chk("R7 rd_done wide", rd_cnt - rd0, 1);

        // R8 narrow mode
        set_width(1'b0);
        chk("R8 narrow", int'(wide_mode), 0);

        // R5 narrow writes
        begin
            logic [7:0] t;
            xfer(1'b0, 1'b0, 8'h2F, t);
            settle();
            chk("R5 no strobe after upper", obs_q.size(), 0);
            xfer(1'b0, 1'b0, 8'h8F, t);
            exp_q.push_back({1'b0, 8'h28});
            cmp_cmds("R5 instr");
        end
        wr4(1'b1, 8'hC3);
        cmp_cmds("R5 data");

        // R6 narrow reads, R7 on second nibble only
        core_busy = 1'b1; core_ac = 7'h12; core_rd_data = 8'h3E;
        xfer(1'b0, 1'b1, 8'h00, s);
        xfer(1'b0, 1'b1, 8'h00, s2);
        chk("R6 status upper", int'(s), 8'h90);
        chk("R6 status lower", int'(s2), 8'h20);
        rd0 = rd_cnt;
        xfer(1'b1, 1'b1, 8'h00, s);
        settle();
        chk("R7 no rd_done after upper", rd_cnt - rd0, 0);
        xfer(1'b1, 1'b1, 8'h00, s2);
        settle();
        chk("R6 data upper", int'(s), 8'h30);
        chk("R6 data lower", int'(s2), 8'hE0);
        chk("R7 rd_done narrow", rd_cnt - rd0, 1);

        // R8 phase reset on width change
        xfer(1'b1, 1'b0, 8'hF0, s);
        set_width(1'b1);
        chk("R8 wide again", int'(wide_mode), 1);
        wr8(1'b0, 8'h0C);
        cmp_cmds("R8 wide write");
        set_width(1'b0);
        wr4(1'b0, 8'h06);
        cmp_cmds("R8 phase reset");

        // R10 test mode entry with restart
        wr4(1'b0, 8'h00);
        settle();
        chk("R10 one zero", int'(test_mode), 0);
        wr4(1'b1, 8'h11);
        wr4(1'b0, 8'h00);
        settle();
        chk("R10 restart", int'(test_mode), 0);
        wr4(1'b0, 8'h00);
        settle();
        chk("R10 entered", int'(test_mode), 1);
        cmp_cmds("R9 R10 narrow");
        set_width(1'b1);
        chk("R10 exit", int'(test_mode), 0);
        chk("R10 wide", int'(wide_mode), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule